// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides when a small processor core stops its current instruction stream to enter an interrupt service routine, and it steps the core through that entry and through the later return. Three sources can start an entry. The first is a level-sensitive maskable request, gated by the architectural interrupt-enable flag. The second is an edge-triggered non-maskable request that the enable flag cannot block. The third is a software interrupt instruction that carries its own type number. A return-from-interrupt instruction starts the reverse, restore sequence. A request is only taken on a cycle where the core signals that its current memory cycle has completed.

An entry is a fixed run of one-cycle strobes with no gaps. The flags are pushed first, then the program counter, and then the enable flag is written to zero. An acknowledge pulse follows, and a maskable source drives its 8-bit type code during that pulse. Two vector table reads come last. The vector table holds four bytes per type: a 2-byte offset at `type*4`, which loads the instruction pointer, and a 2-byte segment at `type*4+2`, which loads the code segment. A return pops the program counter and then the flags. During the flag pop, the enable flag is rewritten from the popped value. The stack memory, the datapath and the instruction decode lie outside the block, and they see only these strobes.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While `ie_i` is 0 a held maskable request (`mask_req_i`) never starts a sequence; when `ie_i` is 1 it is taken at the next boundary.
- R2: A non-maskable request is taken whatever the value of `ie_i`.
- R3: A request is taken only at a clock edge where `cyc_end_i` is 1; the first strobe of the sequence appears in the cycle after that edge.
- R4: An entry drives, in consecutive cycles, `push_flags_o`, then `push_pc_o`, then `ie_wr_o` with `ie_o` = 0.
- R5: The cycle after the enable write is the acknowledge cycle; `ack_o` is 1 in it only for a maskable entry, and the type of a maskable entry is the value on `dev_type_i` in that cycle.
- R6: A non-maskable entry uses type 2; a software entry uses the `swi_type_i` value present at the edge where it is taken, later changes having no effect.
- R7: The two cycles after the acknowledge cycle read the vector table: first `vec_rd_o`, `ld_ip_o` with `vec_addr_o` = type*4, then `vec_rd_o`, `ld_cs_o` with `vec_addr_o` = type*4+2.
- R8: When several sources are pending at one boundary the order is non-maskable, then maskable (if enabled), then software interrupt, then return; the loser stays pending and is taken at the next boundary after the winner ends.
- R9: One rising edge of `nmi_i` produces exactly one entry, whether the line stays high or falls again before the next boundary.
- R10: A return drives `pop_pc_o` for one cycle, then `pop_flags_o` together with `ie_wr_o`, `ie_o` equal to `pop_ie_i`.
- R11: `busy_o` is 1 for every cycle of a sequence; `done_o` pulses in its last cycle; at most one of the push, acknowledge, vector-load and pop strobes is active at a time.
- R12: After reset every output is 0 and no non-maskable request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_req_i | input | 1 | Maskable request level from devices |
| nmi_i | input | 1 | Non-maskable request, rising edge counts |
| ie_i | input | 1 | Current interrupt-enable flag |
| cyc_end_i | input | 1 | Current memory cycle completes at this edge |
| dev_type_i | input | 8 | Type code driven by the device while acknowledged |
| swi_req_i | input | 1 | Software interrupt instruction pending (held until done) |
| swi_type_i | input | 8 | Type code from the software interrupt instruction |
| ret_req_i | input | 1 | Return-from-interrupt instruction pending (held until done) |
| pop_ie_i | input | 1 | Enable bit of the flags word being popped |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Last cycle of a sequence |
| push_flags_o | output | 1 | Push flags to stack |
| push_pc_o | output | 1 | Push code segment and instruction pointer |
| ie_wr_o | output | 1 | Write the enable flag with `ie_o` |
| ie_o | output | 1 | New enable flag value |
| ack_o | output | 1 | Interrupt acknowledge to the maskable source |
| vec_rd_o | output | 1 | Vector table read |
| vec_addr_o | output | 10 | Vector table byte address |
| ld_ip_o | output | 1 | Load instruction pointer from read data |
| ld_cs_o | output | 1 | Load code segment from read data |
| pop_pc_o | output | 1 | Pop code segment and instruction pointer |
| pop_flags_o | output | 1 | Pop flags |

## Verification
Every strobe comes from the sequencer state register. The first strobe of an entry or return is therefore due exactly one cycle after the boundary edge that takes the request, and each following strobe is due one cycle after the one before it. The maskable type is captured at the edge that ends the acknowledge cycle, so it first shows on `vec_addr_o` one cycle later. A non-maskable edge is latched at one edge and can be taken at the next boundary edge, so `nmi_i` must be raised at least one edge before the boundary. The bench drives inputs and samples outputs at falling edges, and it compares the whole strobe word and the address in each of these cycles.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_PUSH_PC,
        ST_MASK,
        ST_ACK,
        ST_VEC_OFF,
        ST_VEC_SEG,
        ST_POP_PC,
        ST_POP_FL
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_MASK,
        SRC_SWI,
        SRC_RET
    } req_src_e;

    typedef struct packed {
        logic level;
        logic pend;
    } nmi_state_t;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch
    import irq_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic take_i,
    output logic pend_o
);

    nmi_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        rise        = nmi_i & ~st_q.level;
        st_d.level  = nmi_i;
        st_d.pend   = (st_q.pend & ~take_i) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb
    import irq_entry_pkg::*;
(
    input  logic     nmi_pend_i,
    input  logic     mask_req_i,
    input  logic     ie_i,
    input  logic     swi_req_i,
    input  logic     ret_req_i,
    output req_src_e src_o
);

    logic mask_ok;

    always_comb begin
        mask_ok = mask_req_i & ie_i;
        if (nmi_pend_i) begin
            src_o = SRC_NMI;
        end else if (mask_ok) begin
            src_o = SRC_MASK;
        end else if (swi_req_i) begin
            src_o = SRC_SWI;
        end else if (ret_req_i) begin
            src_o = SRC_RET;
        end else begin
            src_o = SRC_NONE;
        end
    end

endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter  int TYPE_W     = 8,
    parameter  int SLOT_BYTES = 4,
    parameter  int SEG_OFS    = 2,
    localparam int SLOT_SH    = $clog2(SLOT_BYTES),
    localparam int ADDR_W     = TYPE_W + SLOT_SH
) (
    input  logic [TYPE_W-1:0] type_i,
    input  logic              seg_sel_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] base;

    generate
        if ((SLOT_BYTES & (SLOT_BYTES - 1)) == 0) begin : g_shift
            assign base = ADDR_W'(type_i) << SLOT_SH;
        end else begin : g_mult
            assign base = ADDR_W'(type_i) * ADDR_W'(SLOT_BYTES);
        end
    endgenerate

    assign addr_o = base + (seg_sel_i ? ADDR_W'(SEG_OFS) : '0);

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter  int TYPE_W     = 8,
    parameter  int NMI_TYPE   = 2,
    parameter  int SLOT_BYTES = 4,
    parameter  int SEG_OFS    = 2,
    localparam int ADDR_W     = TYPE_W + $clog2(SLOT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_req_i,
    input  logic              nmi_i,
    input  logic              ie_i,
    input  logic              cyc_end_i,
    input  logic [TYPE_W-1:0] dev_type_i,
    input  logic              swi_req_i,
    input  logic [TYPE_W-1:0] swi_type_i,
    input  logic              ret_req_i,
    input  logic              pop_ie_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              push_flags_o,
    output logic              push_pc_o,
    output logic              ie_wr_o,
    output logic              ie_o,
    output logic              ack_o,
    output logic              vec_rd_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              ld_ip_o,
    output logic              ld_cs_o,
    output logic              pop_pc_o,
    output logic              pop_flags_o
);

    typedef struct packed {
        seq_state_e        st;
        req_src_e          src;
        logic [TYPE_W-1:0] vtype;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    logic     nmi_pend;
    logic     take_nmi;
    req_src_e arb_src;

    irq_nmi_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .take_i (take_nmi),
        .pend_o (nmi_pend)
    );

    irq_src_arb u_arb (
        .nmi_pend_i (nmi_pend),
        .mask_req_i (mask_req_i),
        .ie_i       (ie_i),
        .swi_req_i  (swi_req_i),
        .ret_req_i  (ret_req_i),
        .src_o      (arb_src)
    );

    irq_vec_addr #(
        .TYPE_W     (TYPE_W),
        .SLOT_BYTES (SLOT_BYTES),
        .SEG_OFS    (SEG_OFS)
    ) u_vec (
        .type_i    (ctl_q.vtype),
        .seg_sel_i (ctl_q.st == ST_VEC_SEG),
        .addr_o    (vec_addr_o)
    );

    // next-state computation for the sequencer
    always_comb begin
        ctl_d    = ctl_q;
        take_nmi = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cyc_end_i && (arb_src != SRC_NONE)) begin
                    ctl_d.src = arb_src;
                    ctl_d.st  = (arb_src == SRC_RET) ? ST_POP_PC : ST_PUSH_FL;
                    if (arb_src == SRC_NMI) begin
                        ctl_d.vtype = TYPE_W'(NMI_TYPE);
                        take_nmi    = 1'b1;
                    end else begin
                        ctl_d.vtype = swi_type_i;
                    end
                end
            end
            ST_PUSH_FL: ctl_d.st = ST_PUSH_PC;
            ST_PUSH_PC: ctl_d.st = ST_MASK;
            ST_MASK:    ctl_d.st = ST_ACK;
            ST_ACK: begin
                ctl_d.st = ST_VEC_OFF;
                if (ctl_q.src == SRC_MASK) begin
                    ctl_d.vtype = dev_type_i;
                end
            end
            ST_VEC_OFF: ctl_d.st = ST_VEC_SEG;
            ST_VEC_SEG: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.src = SRC_NONE;
            end
            ST_POP_PC:  ctl_d.st = ST_POP_FL;
            ST_POP_FL: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.src = SRC_NONE;
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.src = SRC_NONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.src   <= SRC_NONE;
            ctl_q.vtype <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // strobes decoded from the state register
    assign busy_o       = (ctl_q.st != ST_IDLE);
    assign push_flags_o = (ctl_q.st == ST_PUSH_FL);
    assign push_pc_o    = (ctl_q.st == ST_PUSH_PC);
    assign ie_wr_o      = (ctl_q.st == ST_MASK) || (ctl_q.st == ST_POP_FL);
    assign ie_o         = (ctl_q.st == ST_POP_FL) && pop_ie_i;
    assign ack_o        = (ctl_q.st == ST_ACK) && (ctl_q.src == SRC_MASK);
    assign ld_ip_o      = (ctl_q.st == ST_VEC_OFF);
    assign ld_cs_o      = (ctl_q.st == ST_VEC_SEG);
    assign vec_rd_o     = ld_ip_o || ld_cs_o;
    assign pop_pc_o     = (ctl_q.st == ST_POP_PC);
    assign pop_flags_o  = (ctl_q.st == ST_POP_FL);
    assign done_o       = ld_cs_o || pop_flags_o;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_end_i,
    input logic              pop_ie_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              push_flags_o,
    input logic              push_pc_o,
    input logic              ie_wr_o,
    input logic              ie_o,
    input logic              ack_o,
    input logic              vec_rd_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic              ld_ip_o,
    input logic              ld_cs_o,
    input logic              pop_pc_o,
    input logic              pop_flags_o
);

    p_start_on_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cyc_end_i));

    p_pc_after_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_flags_o |=> push_pc_o);

    p_disable_after_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_pc_o |=> (ie_wr_o && !ie_o));

    p_ack_after_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(ie_wr_o) && !$past(ie_o)));

    p_offset_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ip_o |-> (vec_rd_o && (vec_addr_o[1:0] == 2'b00)));

    p_segment_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ip_o |=> (ld_cs_o && vec_rd_o && (vec_addr_o == $past(vec_addr_o) + ADDR_W'(2))));

    p_restore_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop_pc_o |=> (pop_flags_o && ie_wr_o && (ie_o == pop_ie_i)));

    p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_flags_o, push_pc_o, ack_o, ld_ip_o, ld_cs_o, pop_pc_o, pop_flags_o}));

    p_done_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

bind irq_entry_ctrl irq_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_end_i    (cyc_end_i),
    .pop_ie_i     (pop_ie_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .push_flags_o (push_flags_o),
    .push_pc_o    (push_pc_o),
    .ie_wr_o      (ie_wr_o),
    .ie_o         (ie_o),
    .ack_o        (ack_o),
    .vec_rd_o     (vec_rd_o),
    .vec_addr_o   (vec_addr_o),
    .ld_ip_o      (ld_ip_o),
    .ld_cs_o      (ld_cs_o),
    .pop_pc_o     (pop_pc_o),
    .pop_flags_o  (pop_flags_o)
);

// File: tb/sim_irq_entry_ctrl.sv
`timescale 1ns/1ps
module sim_irq_entry_ctrl;

    localparam logic [11:0] B_PF   = 12'h800;
    localparam logic [11:0] B_PP   = 12'h400;
    localparam logic [11:0] B_IEW  = 12'h200;
    localparam logic [11:0] B_IEV  = 12'h100;
    localparam logic [11:0] B_ACK  = 12'h080;
    localparam logic [11:0] B_VR   = 12'h040;
    localparam logic [11:0] B_IP   = 12'h020;
    localparam logic [11:0] B_CS   = 12'h010;
    localparam logic [11:0] B_RPC  = 12'h008;
    localparam logic [11:0] B_RFL  = 12'h004;
    localparam logic [11:0] B_DONE = 12'h002;
    localparam logic [11:0] B_BUSY = 12'h001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mask_req_i = 1'b0;
    logic       nmi_i = 1'b0;
    logic       ie_i = 1'b0;
    logic       cyc_end_i = 1'b0;
    logic [7:0] dev_type_i = 8'h00;
    logic       swi_req_i = 1'b0;
    logic [7:0] swi_type_i = 8'h00;
    logic       ret_req_i = 1'b0;
    logic       pop_ie_i = 1'b0;
    logic       busy_o, done_o, push_flags_o, push_pc_o, ie_wr_o, ie_o, ack_o;
    logic       vec_rd_o, ld_ip_o, ld_cs_o, pop_pc_o, pop_flags_o;
    logic [9:0] vec_addr_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mask_req_i(mask_req_i), .nmi_i(nmi_i),
        .ie_i(ie_i), .cyc_end_i(cyc_end_i), .dev_type_i(dev_type_i),
        .swi_req_i(swi_req_i), .swi_type_i(swi_type_i), .ret_req_i(ret_req_i),
        .pop_ie_i(pop_ie_i), .busy_o(busy_o), .done_o(done_o),
        .push_flags_o(push_flags_o), .push_pc_o(push_pc_o), .ie_wr_o(ie_wr_o),
        .ie_o(ie_o), .ack_o(ack_o), .vec_rd_o(vec_rd_o), .vec_addr_o(vec_addr_o),
        .ld_ip_o(ld_ip_o), .ld_cs_o(ld_cs_o), .pop_pc_o(pop_pc_o),
        .pop_flags_o(pop_flags_o)
    );

    function automatic logic [11:0] obs();
        return {push_flags_o, push_pc_o, ie_wr_o, ie_o, ack_o, vec_rd_o,
                ld_ip_o, ld_cs_o, pop_pc_o, pop_flags_o, done_o, busy_o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // src: 0 non-maskable, 1 maskable, 2 software
    task automatic check_entry(input int src, input logic [7:0] t, input string req);
        logic [9:0] base;
        base = {t, 2'b00};
        chk("R4", 32'(obs()), 32'(B_PF | B_BUSY));
        if (src == 2) swi_type_i = ~t;
        @(negedge clk);
        chk("R4", 32'(obs()), 32'(B_PP | B_BUSY));
        @(negedge clk);
        chk("R4", 32'(obs()), 32'(B_IEW | B_BUSY));
        @(negedge clk);
        chk("R5", 32'(obs()), 32'(((src == 1) ? B_ACK : 12'h000) | B_BUSY));
        if (src == 1) mask_req_i = 1'b0;
        @(negedge clk);
        chk("R7", 32'(obs()), 32'(B_VR | B_IP | B_BUSY));
        chk(req, 32'(vec_addr_o), 32'(base));
        @(negedge clk);
        chk("R11", 32'(obs()), 32'(B_VR | B_CS | B_DONE | B_BUSY));
        chk(req, 32'(vec_addr_o), 32'(base + 10'd2));
        if (src == 2) swi_req_i = 1'b0;
        @(negedge clk);
        chk("R11", 32'(obs()), 32'h0);
    endtask

    task automatic check_ret(input logic pie);
        chk("R10", 32'(obs()), 32'(B_RPC | B_BUSY));
        @(negedge clk);
        chk("R10", 32'(obs()), 32'(B_RFL | B_IEW | (pie ? B_IEV : 12'h000) | B_DONE | B_BUSY));
        ret_req_i = 1'b0;
        @(negedge clk);
        chk("R11", 32'(obs()), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", 32'(obs()), 32'h0);
        repeat (3) @(negedge clk);
        chk("R12", 32'(obs()), 32'h0);

        // R5 R7: every maskable type
        ie_i = 1'b1;
        for (int t = 0; t < 256; t++) begin
            dev_type_i = 8'(t);
            swi_type_i = ~8'(t);
            mask_req_i = 1'b1;
            cyc_end_i = 1'b1;
            @(negedge clk);
            cyc_end_i = 1'b0;
            check_entry(1, 8'(t), "R5");
        end

        // R1: enable flag clear blocks maskable request
        ie_i = 1'b0;
        mask_req_i = 1'b1;
        cyc_end_i = 1'b1;
        dev_type_i = 8'h3C;
        repeat (16) begin
            @(negedge clk);
            chk("R1", 32'(obs()), 32'h0);
        end
        ie_i = 1'b1;
        @(negedge clk);
        cyc_end_i = 1'b0;
        check_entry(1, 8'h3C, "R1");

        // R3: no acceptance off a cycle boundary
        mask_req_i = 1'b1;
        dev_type_i = 8'hA5;
        repeat (12) begin
            @(negedge clk);
            chk("R3", 32'(obs()), 32'h0);
        end
        cyc_end_i = 1'b1;
        @(negedge clk);
        cyc_end_i = 1'b0;
        check_entry(1, 8'hA5, "R3");

        // R2 R9: non-maskable with enable clear, held high
        ie_i = 1'b0;
        mask_req_i = 1'b0;
        nmi_i = 1'b1;
        @(negedge clk);
        chk("R3", 32'(obs()), 32'h0);
        cyc_end_i = 1'b1;
        @(negedge clk);
        check_entry(0, 8'd2, "R2");
        repeat (20) begin
            @(negedge clk);
            chk("R9", 32'(obs()), 32'h0);
        end
        nmi_i = 1'b0;
        @(negedge clk);
        nmi_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_entry(0, 8'd2, "R6");

        // R9: short pulse is latched until a boundary
        cyc_end_i = 1'b0;
        nmi_i = 1'b0;
        @(negedge clk);
        nmi_i = 1'b1;
        @(negedge clk);
        nmi_i = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk("R9", 32'(obs()), 32'h0);
        end
        cyc_end_i = 1'b1;
        @(negedge clk);
        check_entry(0, 8'd2, "R9");
        repeat (4) begin
            @(negedge clk);
            chk("R9", 32'(obs()), 32'h0);
        end

        // R8: non-maskable beats maskable
        cyc_end_i = 1'b0;
        ie_i = 1'b1;
        mask_req_i = 1'b1;
        dev_type_i = 8'h47;
        nmi_i = 1'b1;
        @(negedge clk);
        cyc_end_i = 1'b1;
        @(negedge clk);
        check_entry(0, 8'd2, "R8");
        @(negedge clk);
        check_entry(1, 8'h47, "R8");
        nmi_i = 1'b0;

        // R8: maskable beats software
        mask_req_i = 1'b1;
        dev_type_i = 8'h11;
        swi_req_i = 1'b1;
        swi_type_i = 8'h99;
        @(negedge clk);
        check_entry(1, 8'h11, "R8");
        swi_type_i = 8'h99;
        @(negedge clk);
        check_entry(2, 8'h99, "R8");

        // R8: software beats return
        ie_i = 1'b0;
        swi_req_i = 1'b1;
        swi_type_i = 8'h5A;
        ret_req_i = 1'b1;
        pop_ie_i = 1'b1;
        @(negedge clk);
        check_entry(2, 8'h5A, "R8");
        @(negedge clk);
        check_ret(1'b1);
        cyc_end_i = 1'b0;

        // R6: software types, latched at acceptance
        for (int t = 0; t < 256; t += 17) begin
            swi_type_i = 8'(t);
            swi_req_i = 1'b1;
            cyc_end_i = 1'b1;
            @(negedge clk);
            cyc_end_i = 1'b0;
            check_entry(2, 8'(t), "R6");
        end

        // R10: return with both popped enable values
        for (int p = 0; p < 2; p++) begin
            pop_ie_i = p[0];
            ret_req_i = 1'b1;
            cyc_end_i = 1'b1;
            @(negedge clk);
            cyc_end_i = 1'b0;
            check_ret(p[0]);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule